// File: doc/BRIEF.md
# Configurable-Width One-Time-Programmable ROM Port

This block is the device-side control of a one-time-programmable memory. It turns five control pins (chip select, output enable, width select, a signature flag that stands for a high voltage on an address line, and a program-supply flag) into one operating mode per cycle. The modes are word read, byte read, output disable, standby, program, verify, program inhibit and identifier read. The storage is a small register array. It is addressed by whole 16-bit words and drives a 16-bit output bus split into three lanes, each with its own enable: bits 7..0, bits 14..8 and bit 15.

In byte organisation, the pin that carries data bit 15 in word organisation becomes an extra, lowest-order address input (`shared_in`). That input selects which half of the addressed word appears on the low lane. Access latency is modelled in clock cycles. A change of address, organisation or flag, or a newly selected device, starts the full access window. A falling output enable starts the shorter output-enable window, and the later of the two windows governs. `data_valid` is the only qualifier. It has no ready partner, so a consumer cannot apply back-pressure. Data is offered while `data_valid` is high, and `data_out` is zero whenever `data_valid` is low.

Top module: `otp_rom_port`

## Requirements
- R1: After reset every word holds 0xFFFF, and a word read of a location never programmed returns 0xFFFF.
- R2: With `prog_hv`=0, `ce_n`=0, `oe_n`=0, `sig_hv`=0 and `wide_sel`=1, all three lane enables are high and, once valid, `data_out` equals the stored word at `addr`.
- R3: With `wide_sel`=0 (and `prog_hv`=0, `sig_hv`=0, `ce_n`=0, `oe_n`=0), only `lane_lo_oe` is high. `data_out[7:0]` is bits 7..0 of the word when `shared_in`=0 and bits 15..8 when `shared_in`=1. Bits 15..8 of `data_out` are 0.
- R4: With `prog_hv`=0, `ce_n`=0 and `oe_n`=1, all lane enables are low and `data_out` is 0.
- R5: With `prog_hv`=0 and `ce_n`=1, all lane enables are low and `data_out` is 0, whatever the value of `oe_n`.
- R6: Counting clock edges at which `addr`, `wide_sel`, `sig_hv`, `prog_hv` and (in byte organisation) `shared_in` are unchanged and the device is selected (`ce_n`=0, or `prog_hv`=1), `data_valid` rises only after ACC_CYC+1 such edges. While `data_valid` is low, `data_out` is 0.
- R7: After `oe_n` falls with the address already settled, `data_valid` rises after exactly OE_CYC+1 edges with `oe_n` low. It is low in the cycle of the fall.
- R8: With `sig_hv`=1 in a read, only the low lane is driven. It carries 0x20 when `addr`=0 and 0xB1 when `addr`=1, and 0x00 when any bit of `addr` above bit 0 is set.
- R9: With `prog_hv`=1, `ce_n`=0 and `oe_n`=1, each clock edge replaces the word at `addr` with (old AND `din`), and no lane is driven.
- R10: With `prog_hv`=1, `ce_n`=1 and `oe_n`=0 (verify), all three lanes drive the full stored word once valid.
- R11: With `prog_hv`=1, `ce_n`=1 and `oe_n`=1 (inhibit), no lane is driven and the array is unchanged.
- R12: With `prog_hv`=1, `ce_n`=0 and `oe_n`=0, no lane is driven and the array is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; erases the array to all ones |
| ce_n | input | 1 | Active-low chip select; write strobe in program mode |
| oe_n | input | 1 | Active-low output enable |
| wide_sel | input | 1 | 1 = 16-bit organisation, 0 = 8-bit organisation |
| sig_hv | input | 1 | Identifier-read flag |
| prog_hv | input | 1 | Program-supply flag |
| addr | input | AW | Word address |
| shared_in | input | 1 | Half-word select in byte organisation |
| din | input | 16 | Data to program |
| data_out | output | 16 | Output bus value |
| data_valid | output | 1 | Output bus holds settled data |
| lane_lo_oe | output | 1 | Drive enable for bits 7..0 |
| lane_mid_oe | output | 1 | Drive enable for bits 14..8 |
| bit15_oe | output | 1 | Drive enable for bit 15 |

## Verification
The hardest state to reach from the ports is a falling output enable while the access window of an address change is still counting down. Only there does the later of the two windows decide when data becomes valid. The stimulus reaches it by changing the address and then releasing `oe_n` a few cycles later, inside the window. It also releases `oe_n` long after the address has settled. Program inhibit and the conflicting program state leave no trace on the bus, so their effect on the array is observed through a later verify of the same word.

// File: rtl/otp_rom_pkg.sv
`timescale 1ns/1ps
package otp_rom_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] MFR_CODE = 8'h20;
  localparam logic [BYTE_W-1:0] DEV_CODE = 8'hB1;

  typedef enum logic [3:0] {
    MD_STANDBY, MD_DISABLE, MD_WORD, MD_BYTE, MD_IDENT,
    MD_PROG, MD_VERIFY, MD_INHIBIT, MD_CONFLICT
  } rom_mode_e;
endpackage

// File: rtl/otp_mode_dec.sv
`timescale 1ns/1ps
module otp_mode_dec
  import otp_rom_pkg::*;
(
  input  logic      ce_n,
  input  logic      oe_n,
  input  logic      wide_sel,
  input  logic      sig_hv,
  input  logic      prog_hv,
  output rom_mode_e mode,
  output logic      lo_en,
  output logic      mid_en,
  output logic      top_en
);
  always_comb begin
    if (prog_hv) begin
      unique case ({ce_n, oe_n})
        2'b01:   mode = MD_PROG;
        2'b10:   mode = MD_VERIFY;
        2'b11:   mode = MD_INHIBIT;
        default: mode = MD_CONFLICT;
      endcase
    end else if (ce_n)    mode = MD_STANDBY;
    else if (oe_n)        mode = MD_DISABLE;
    else if (sig_hv)      mode = MD_IDENT;
    else if (wide_sel)    mode = MD_WORD;
    else                  mode = MD_BYTE;
  end

  always_comb begin
    lo_en  = (mode == MD_WORD) || (mode == MD_BYTE) ||
             (mode == MD_IDENT) || (mode == MD_VERIFY);
    mid_en = (mode == MD_WORD) || (mode == MD_VERIFY);
    top_en = mid_en;
  end
endmodule

// File: rtl/otp_access_timer.sv
`timescale 1ns/1ps
module otp_access_timer #(
  parameter int ACC_CYC = 5,
  parameter int OE_CYC  = 2,
  parameter int KW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic [KW-1:0] key,
  input  logic          oe_n,
  output logic          settled
);
  localparam int CW = $clog2(ACC_CYC + 2);
  localparam logic [CW-1:0] ACC_L = CW'(ACC_CYC);
  localparam logic [CW-1:0] OE_L  = CW'(OE_CYC);
  localparam logic [CW-1:0] OE_P1 = CW'(OE_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic [KW-1:0] key_q;
  logic          sel_q, oe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= ACC_L;
      key_q <= '0;
      sel_q <= 1'b0;
      oe_q  <= 1'b1;
    end else begin
      sel_q <= sel;
      key_q <= key;
      oe_q  <= oe_n;
      if (!sel || !sel_q || key != key_q)
        cnt_q <= ACC_L;
      else if (oe_q && !oe_n)
        cnt_q <= (cnt_q > OE_P1) ? cnt_q - 1'b1 : OE_L;
      else if (cnt_q != '0)
        cnt_q <= cnt_q - 1'b1;
    end
  end

  assign settled = sel && sel_q && (key == key_q) && (oe_n == oe_q) && (cnt_q == '0);
endmodule

// File: rtl/otp_cell_array.sv
`timescale 1ns/1ps
module otp_cell_array
  import otp_rom_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [WORD_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
    end else if (wr_en) begin
      cells[addr] <= cells[addr] & wr_data;
    end
  end

  assign rd_data = cells[addr];
endmodule

// File: rtl/otp_rom_port.sv
`timescale 1ns/1ps
module otp_rom_port
  import otp_rom_pkg::*;
#(
  parameter int AW      = 4,
  parameter int ACC_CYC = 5,
  parameter int OE_CYC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              wide_sel,
  input  logic              sig_hv,
  input  logic              prog_hv,
  input  logic [AW-1:0]     addr,
  input  logic              shared_in,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] data_out,
  output logic              data_valid,
  output logic              lane_lo_oe,
  output logic              lane_mid_oe,
  output logic              bit15_oe
);
  localparam int KW = AW + 4;

  rom_mode_e         mode;
  logic              lo_en, mid_en, top_en, settled, half_sel;
  logic [KW-1:0]     key;
  logic [WORD_W-1:0] word;
  logic [BYTE_W-1:0] lo_val, id_val;

  otp_mode_dec u_dec (
    .ce_n(ce_n), .oe_n(oe_n), .wide_sel(wide_sel), .sig_hv(sig_hv),
    .prog_hv(prog_hv), .mode(mode), .lo_en(lo_en), .mid_en(mid_en), .top_en(top_en)
  );

  assign half_sel = !wide_sel && shared_in;
  assign key      = {addr, half_sel, wide_sel, sig_hv, prog_hv};

  otp_access_timer #(.ACC_CYC(ACC_CYC), .OE_CYC(OE_CYC), .KW(KW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .sel(!ce_n || prog_hv), .key(key),
    .oe_n(oe_n), .settled(settled)
  );

  otp_cell_array #(.AW(AW)) u_arr (
    .clk(clk), .rst_n(rst_n), .wr_en(mode == MD_PROG), .addr(addr),
    .wr_data(din), .rd_data(word)
  );

  always_comb begin
    if (addr[AW-1:1] != '0) id_val = '0;
    else                    id_val = addr[0] ? DEV_CODE : MFR_CODE;
  end

  always_comb begin
    unique case (mode)
      MD_IDENT: lo_val = id_val;
      MD_BYTE:  lo_val = half_sel ? word[WORD_W-1:BYTE_W] : word[BYTE_W-1:0];
      default:  lo_val = word[BYTE_W-1:0];
    endcase
  end

  assign lane_lo_oe  = lo_en;
  assign lane_mid_oe = mid_en;
  assign bit15_oe    = top_en;
  assign data_valid  = settled && lo_en;

  always_comb begin
    data_out = '0;
    if (data_valid) begin
      data_out[BYTE_W-1:0] = lo_val;
      if (mid_en) data_out[WORD_W-2:BYTE_W] = word[WORD_W-2:BYTE_W];
      if (top_en) data_out[WORD_W-1]        = word[WORD_W-1];
    end
  end
endmodule

// File: rtl/otp_rom_port_chk.sv
`timescale 1ns/1ps
module otp_rom_port_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          oe_n,
  input logic          wide_sel,
  input logic          sig_hv,
  input logic          prog_hv,
  input logic [AW-1:0] addr,
  input logic [15:0]   data_out,
  input logic          data_valid,
  input logic          lane_lo_oe,
  input logic          lane_mid_oe,
  input logic          bit15_oe
);
  // R5
  standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && !prog_hv) |-> !(lane_lo_oe || lane_mid_oe || bit15_oe));

  // R4
  disable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && oe_n && !prog_hv) |-> !(lane_lo_oe || lane_mid_oe || bit15_oe));

  // R3
  byte_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!prog_hv && !sig_hv && !wide_sel) |-> (!lane_mid_oe && !bit15_oe));

  // R6
  settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> ($stable(addr) && $stable(prog_hv) && $stable(wide_sel)));

  // R6
  zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_valid |-> (data_out == 16'h0000));

  // R7
  oe_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_n) |-> !data_valid);

  // R9
  prog_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_hv && oe_n) |-> !lane_lo_oe);

  // R12
  conflict_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_hv && !ce_n && !oe_n) |-> !(lane_lo_oe || lane_mid_oe || bit15_oe));
endmodule

bind otp_rom_port otp_rom_port_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .wide_sel(wide_sel),
  .sig_hv(sig_hv), .prog_hv(prog_hv), .addr(addr), .data_out(data_out),
  .data_valid(data_valid), .lane_lo_oe(lane_lo_oe), .lane_mid_oe(lane_mid_oe),
  .bit15_oe(bit15_oe)
);

// File: tb/otp_rom_port_tb_top.sv
`timescale 1ns/1ps
module otp_rom_port_tb_top;
  localparam int AW = 4, ACC = 5, OE = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, ce_n = 1'b1, oe_n = 1'b1, wide_sel = 1'b1, sig_hv = 1'b0;
  logic prog_hv = 1'b0, shared_in = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0] din = '0, data_out;
  logic data_valid, lane_lo_oe, lane_mid_oe, bit15_oe;

  otp_rom_port #(.AW(AW), .ACC_CYC(ACC), .OE_CYC(OE)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .wide_sel(wide_sel),
    .sig_hv(sig_hv), .prog_hv(prog_hv), .addr(addr), .shared_in(shared_in),
    .din(din), .data_out(data_out), .data_valid(data_valid),
    .lane_lo_oe(lane_lo_oe), .lane_mid_oe(lane_mid_oe), .bit15_oe(bit15_oe)
  );

  int checks = 0, errors = 0;
  bit running = 0, done = 0;
  logic [15:0] mem_m [1 << AW];
  int stab_k = 0, stab_o = 0;
  logic [AW+3:0] last_key = '0;
  bit last_sel = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [AW+3:0] cur_key();
    return {addr, (!wide_sel && shared_in), wide_sel, sig_hv, prog_hv};
  endfunction

  function automatic string mode_tag();
    if (prog_hv) begin
      if (!ce_n && oe_n) return "R9";
      if (ce_n && !oe_n) return "R10";
      if (ce_n && oe_n)  return "R11";
      return "R12";
    end
    if (ce_n)     return "R5";
    if (oe_n)     return "R4";
    if (sig_hv)   return "R8";
    if (wide_sel) return "R2";
    return "R3";
  endfunction

  // reference model update on each edge
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < (1 << AW); i++) mem_m[i] = 16'hFFFF;
      stab_k = 0; stab_o = 0; last_sel = 0; last_key = '0;
    end else begin
      bit sel_now;
      sel_now = !ce_n || prog_hv;
      if (prog_hv && !ce_n && oe_n) mem_m[addr] = mem_m[addr] & din;
      if (sel_now && last_sel && cur_key() == last_key) stab_k++;
      else stab_k = sel_now ? 1 : 0;
      stab_o = oe_n ? 0 : stab_o + 1;
      last_sel = sel_now;
      last_key = cur_key();
    end
  end

  // per-cycle comparison against the model, away from the active edge
  initial forever begin
    @(negedge clk); #8;
    if (running) begin
      string tg;
      bit lo, mid, v;
      logic [15:0] w, e;
      logic [7:0] lv;
      tg  = mode_tag();
      lo  = (tg == "R2") || (tg == "R3") || (tg == "R8") || (tg == "R10");
      mid = (tg == "R2") || (tg == "R10");
      v   = lo && (!ce_n || prog_hv) && last_sel && (cur_key() == last_key) &&
            (stab_k >= ACC + 1) && (stab_o >= OE + 1);
      w   = mem_m[addr];
      if (tg == "R8")      lv = (addr >> 1) != 0 ? 8'h00 : (addr[0] ? 8'hB1 : 8'h20);
      else if (tg == "R3") lv = shared_in ? w[15:8] : w[7:0];
      else                 lv = w[7:0];
      e = '0;
      if (v) begin
        e[7:0] = lv;
        if (mid) e[15:8] = w[15:8];
      end
      chk(lane_lo_oe == lo, tg, "lane_lo_oe", lane_lo_oe, lo);
      chk(lane_mid_oe == mid && bit15_oe == mid, tg, "upper lane enables",
          {lane_mid_oe, bit15_oe}, {mid, mid});
      chk(data_valid == v, "R6", "data_valid", data_valid, v);
      chk(data_out == e, tg, "data_out", data_out, e);
    end
  end

  task automatic drive(bit c, bit o, bit wd, bit sg, bit pg, int a, bit sh,
                       logic [15:0] d, int n);
    @(negedge clk); #1;
    ce_n = c; oe_n = o; wide_sel = wd; sig_hv = sg; prog_hv = pg;
    addr = AW'(a); shared_in = sh; din = d;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic peek(string tag, logic [15:0] exp_d, bit exp_v);
    @(negedge clk); #8;
    chk(data_valid == exp_v, tag, "explicit data_valid", data_valid, exp_v);
    if (exp_v) chk(data_out == exp_d, tag, "explicit data_out", data_out, exp_d);
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #8;
    running = 1;
    chk(lane_lo_oe == 0 && data_out == 0, "R5", "reset outputs", data_out, 0);
    drive(1, 0, 1, 0, 0, 3, 0, 0, 4);                  // R5 standby, oe low
    drive(0, 0, 1, 0, 0, 3, 0, 0, ACC + 2);            // R1 fresh word read
    peek("R1", 16'hFFFF, 1);
    drive(0, 0, 1, 0, 0, 9, 0, 0, 2);                  // R6 addr change mid-window
    drive(0, 1, 1, 0, 0, 9, 0, 0, 1);
    drive(0, 0, 1, 0, 0, 9, 0, 0, ACC + 2);            // R7 oe fall inside window
    // programming
    drive(0, 1, 1, 0, 1, 3, 0, 16'h12F4, 3);           // R9
    drive(1, 1, 1, 0, 1, 3, 0, 16'h0000, 3);           // R11 inhibit
    drive(0, 1, 1, 0, 1, 3, 0, 16'hF0FF, 2);           // R9 AND rule
    drive(0, 1, 1, 0, 1, 5, 0, 16'hA55A, 2);
    drive(0, 1, 1, 0, 1, 0, 0, 16'h8001, 2);
    drive(0, 0, 1, 0, 1, 7, 0, 16'h0000, 3);           // R12 no write
    drive(1, 0, 1, 0, 1, 3, 0, 0, ACC + 2);            // R10 verify
    peek("R10", 16'h10F4, 1);
    drive(1, 0, 1, 0, 1, 7, 0, 0, ACC + 2);
    peek("R12", 16'hFFFF, 1);
    // reads
    drive(0, 0, 1, 0, 0, 5, 0, 0, ACC + 2);            // R2
    peek("R2", 16'hA55A, 1);
    drive(0, 1, 1, 0, 0, 5, 0, 0, 8);                  // R4
    drive(0, 0, 1, 0, 0, 5, 0, 0, 1);                  // R7 settled oe fall
    for (int i = 0; i <= OE; i++) peek("R7", 16'hA55A, i == OE);
    drive(1, 0, 1, 0, 0, 5, 0, 0, 3);                  // R5
    drive(0, 0, 0, 0, 0, 5, 0, 0, ACC + 2);            // R3 low half
    peek("R3", 16'h005A, 1);
    drive(0, 0, 0, 0, 0, 5, 1, 0, ACC + 2);            // R3 high half
    peek("R3", 16'h00A5, 1);
    drive(0, 0, 0, 0, 0, 0, 1, 0, ACC + 2);
    peek("R3", 16'h0080, 1);
    drive(0, 0, 1, 1, 0, 0, 0, 0, ACC + 2);            // R8
    peek("R8", 16'h0020, 1);
    drive(0, 0, 1, 1, 0, 1, 0, 0, ACC + 2);
    peek("R8", 16'h00B1, 1);
    drive(0, 0, 1, 1, 0, 2, 0, 0, ACC + 2);
    peek("R8", 16'h0000, 1);
    drive(0, 0, 1, 0, 0, 0, 0, 0, ACC + 2);            // R2
    peek("R2", 16'h8001, 1);
    drive(1, 1, 1, 0, 0, 0, 0, 0, 3);
    running = 0;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule